// File: doc/BRIEF.md
# Self-Triggered Waveform Channel Controller

This block controls one channel of a waveform digitizer. While the channel is armed, it writes the incoming digitized samples into a circular buffer, one cell per clock. A trigger from the selected source stops the writing. The trigger also latches a timestamp from a free-running cycle counter and flags a pending event. The block then requests a conversion through a request/done handshake.

When the conversion completes, the frozen buffer and the timestamp are handed to a readout engine, and the channel re-arms at once. The readout engine streams the event on a 14-bit word bus, one word per cycle: the timestamp first, then a window of cells. The window is given as a start offset from the frozen write pointer and a length.

If a conversion completes while an earlier event is still streaming, the channel stays frozen until the stream finishes and the hand-over can take place.

Top module: `wave_chan_ctrl`

## Requirements
- R1: While reset is asserted, `eventPending`, `convReq` and `dataValid` are all 0.
- R2: While armed, the channel writes one sample per clock into a 64-cell buffer at consecutive addresses, wrapping modulo 64. The frozen pointer is the cell after the triggering sample. Window word i is read from cell (frozen pointer + `roiStart` + i) mod 64. So with start 0 and length 64, the last 64 samples come out oldest first, and the triggering sample comes last.
- R3: On the clock edge that accepts a trigger, the sample present on that edge is the last one stored. `eventPending` reads 1 from the next cycle. The timestamp is the free-running counter value at that edge, where the counter is 0 at the first edge after reset and counts every clock.
- R4: `trigSel` picks the trigger source: 0 selects the local comparator, 1 selects `commonTrig`, 2 selects `extTrig`, and 3 selects no source. Sources that are not selected have no effect.
- R5: The local comparator fires when a sample is strictly greater than `threshold` and the previous clock's sample was not. A sample equal to the threshold does not fire it, and a level held above the threshold does not fire it again.
- R6: `convReq` rises two cycles after the trigger edge and stays high until the first edge that sees `convDone`.
- R7: The readout stream starts one cycle after the hand-over edge. It sends the timestamp word first, then the window samples zero-extended to 14 bits, one word per cycle with `dataValid` high.
- R8: The window length is `roiLenM1`+1, from 1 to 64 cells, so an event produces `roiLenM1`+2 words.
- R9: When `convDone` is seen and no stream is in progress, the hand-over happens on that edge. `eventPending` falls in the next cycle, and new samples and triggers are accepted while the stream runs.
- R10: When `convDone` is seen during a stream, the channel stays frozen with `eventPending` high and `convReq` low. The hand-over happens once that stream has ended, and the new stream follows it.
- R11: A trigger that arrives while an event is pending is ignored, and it does not start a later event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | 12 | Digitized sample, one per clock |
| threshold | input | 12 | Local comparator threshold |
| trigSel | input | 2 | Trigger source select |
| commonTrig | input | 1 | Shared on-chip trigger |
| extTrig | input | 1 | External trigger |
| roiStart | input | 6 | Window start offset from the frozen pointer |
| roiLenM1 | input | 6 | Window length minus one |
| convReq | output | 1 | Conversion request |
| convDone | input | 1 | Conversion finished |
| eventPending | output | 1 | Event frozen and not yet handed to readout |
| dataOut | output | 14 | Readout word |
| dataValid | output | 1 | Readout word valid |

## Verification
The bench builds the block with its default parameters: 64 cells, 12-bit samples and 14-bit words. With these values a full-depth window is reachable, and so is a window that wraps past cell 63. The 2 padding bits on each sample word are also exercised. The 6-bit pointer and offset make the modulo-64 wrap of the start address a real corner. Each source select is checked against decoy pulses and decoy crossings on the sources that are not selected.

// File: rtl/wave_chan_pkg.sv
package wave_chan_pkg;

  typedef enum logic [1:0] {
    CH_ARMED,
    CH_FROZEN,
    CH_CONVERTING,
    CH_RDPEND
  } chanState_e;

  typedef struct packed {
    logic writeEn;
    logic capture;
    logic transfer;
  } ctrlStrobe_t;

  localparam logic [1:0] SEL_LOCAL  = 2'd0;
  localparam logic [1:0] SEL_COMMON = 2'd1;
  localparam logic [1:0] SEL_EXT    = 2'd2;

endpackage

// File: rtl/wave_chan_fsm.sv
module wave_chan_fsm
  import wave_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  trigSel,
  input  logic        localHit,
  input  logic        commonTrig,
  input  logic        extTrig,
  input  logic        convDone,
  input  logic        rdBusy,
  output ctrlStrobe_t strb,
  output logic        convReq,
  output logic        eventPending
);

  chanState_e state, stateNext;
  logic trigFire;

  always_comb begin
    case (trigSel)
      SEL_LOCAL:  trigFire = localHit;
      SEL_COMMON: trigFire = commonTrig;
      SEL_EXT:    trigFire = extTrig;
      default:    trigFire = 1'b0;
    endcase
  end

  always_comb begin
    stateNext = state;
    strb = '0;
    case (state)
      CH_ARMED: begin
        strb.writeEn = 1'b1;
        if (trigFire) begin
          strb.capture = 1'b1;
          stateNext = CH_FROZEN;
        end
      end
      CH_FROZEN: stateNext = CH_CONVERTING;
      CH_CONVERTING: begin
        if (convDone) begin
          if (rdBusy) begin
            stateNext = CH_RDPEND;
          end else begin
            strb.transfer = 1'b1;
            stateNext = CH_ARMED;
          end
        end
      end
      CH_RDPEND: begin
        if (!rdBusy) begin
          strb.transfer = 1'b1;
          stateNext = CH_ARMED;
        end
      end
      default: stateNext = CH_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= CH_ARMED;
    else       state <= stateNext;
  end

  assign convReq      = (state == CH_CONVERTING);
  assign eventPending = (state != CH_ARMED);

  AST_TRIG_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (state == CH_ARMED && trigFire) |=> eventPending); // R3
  AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && !convDone) |=> convReq); // R6
  AST_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && convDone && !rdBusy) |=> !eventPending); // R9
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && convDone && rdBusy) |=> (eventPending && !convReq)); // R10
  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rstN)
    (state == CH_CONVERTING && !convDone) |=> eventPending); // R11

endmodule

// File: rtl/wave_chan_path.sv
module wave_chan_path
  import wave_chan_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 14,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int LEN_W   = PTR_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [PTR_W-1:0]    roiStart,
  input  logic [PTR_W-1:0]    roiLenM1,
  output logic                localHit,
  output logic                rdBusy,
  output logic [WORD_W-1:0]   dataOut,
  output logic                dataValid
);

  logic [SAMPLE_W-1:0] mem  [DEPTH];
  logic [SAMPLE_W-1:0] bank [DEPTH];
  logic [PTR_W-1:0]    wrPtr, rdAddr;
  logic [LEN_W-1:0]    rdCnt, rdLen;
  logic [WORD_W-1:0]   tsCnt, tsFrozen, tsHold, sampleWord;
  logic                prevAbove, aboveNow;

  assign aboveNow = (sampleIn > threshold);
  assign localHit = aboveNow && !prevAbove;

  generate
    if (WORD_W > SAMPLE_W) begin : g_pad
      assign sampleWord = {{(WORD_W-SAMPLE_W){1'b0}}, bank[rdAddr]};
    end else begin : g_trunc
      assign sampleWord = bank[rdAddr][WORD_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.writeEn)  mem[wrPtr] <= sampleIn;
    if (strb.transfer) bank <= mem;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      prevAbove <= 1'b1;
      tsCnt     <= '0;
      tsFrozen  <= '0;
      tsHold    <= '0;
      rdBusy    <= 1'b0;
      rdCnt     <= '0;
      rdLen     <= '0;
      rdAddr    <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      tsCnt     <= tsCnt + 1'b1;
      prevAbove <= aboveNow;
      if (strb.writeEn) wrPtr <= wrPtr + 1'b1;
      if (strb.capture) tsFrozen <= tsCnt;
      if (strb.transfer) begin
        rdBusy    <= 1'b1;
        rdCnt     <= '0;
        rdLen     <= LEN_W'(roiLenM1) + LEN_W'(1);
        rdAddr    <= wrPtr + roiStart;
        tsHold    <= tsFrozen;
        dataValid <= 1'b0;
      end else if (rdBusy) begin
        dataValid <= 1'b1;
        dataOut   <= (rdCnt == '0) ? tsHold : sampleWord;
        if (rdCnt != '0) rdAddr <= rdAddr + 1'b1;
        if (rdCnt == rdLen) rdBusy <= 1'b0;
        rdCnt <= rdCnt + 1'b1;
      end else begin
        dataValid <= 1'b0;
      end
    end
  end

  AST_STREAM_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $past(strb.transfer, 2)); // R7
  AST_STREAM_LEN: assert property (@(posedge clk) disable iff (!rstN)
    rdBusy |-> (rdCnt <= rdLen)); // R8
  AST_FROZEN_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.writeEn && !$past(strb.writeEn)) |-> $stable(wrPtr)); // R2

endmodule

// File: rtl/wave_chan_ctrl.sv
module wave_chan_ctrl
  import wave_chan_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 14,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [1:0]          trigSel,
  input  logic                commonTrig,
  input  logic                extTrig,
  input  logic [PTR_W-1:0]    roiStart,
  input  logic [PTR_W-1:0]    roiLenM1,
  output logic                convReq,
  input  logic                convDone,
  output logic                eventPending,
  output logic [WORD_W-1:0]   dataOut,
  output logic                dataValid
);

  ctrlStrobe_t strb;
  logic localHit, rdBusy;

  wave_chan_fsm u_fsm (
    .clk(clk), .rstN(rstN), .trigSel(trigSel), .localHit(localHit),
    .commonTrig(commonTrig), .extTrig(extTrig), .convDone(convDone),
    .rdBusy(rdBusy), .strb(strb), .convReq(convReq),
    .eventPending(eventPending)
  );

  wave_chan_path #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleIn(sampleIn),
    .threshold(threshold), .roiStart(roiStart), .roiLenM1(roiLenM1),
    .localHit(localHit), .rdBusy(rdBusy), .dataOut(dataOut),
    .dataValid(dataValid)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!eventPending && !convReq && !dataValid)); // R1

endmodule

// File: tb/wave_chan_ctrl_tb_top.sv
module wave_chan_ctrl_tb_top;
  localparam int SW = 12;
  localparam int WW = 14;
  localparam int THR = 2000;
  // {sel[31:30], start[29:24], lenM1[23:18], base[17:8], lat[7:0]}
  localparam logic [31:0] VEC [6] = '{
    {2'd0, 6'd0,  6'd63, 10'd5,   8'd3},
    {2'd1, 6'd10, 6'd7,  10'd100, 8'd5},
    {2'd2, 6'd60, 6'd9,  10'd33,  8'd2},
    {2'd0, 6'd63, 6'd0,  10'd7,   8'd4},
    {2'd1, 6'd32, 6'd31, 10'd200, 8'd10},
    {2'd2, 6'd0,  6'd0,  10'd1,   8'd1}
  };

  logic clk = 0, rstN = 0;
  logic [SW-1:0] sampleIn = '0, threshold = SW'(THR);
  logic [1:0] trigSel = '0;
  logic commonTrig = 0, extTrig = 0, convDone = 0;
  logic [5:0] roiStart = '0, roiLenM1 = '0;
  logic convReq, eventPending, dataValid;
  logic [WW-1:0] dataOut;
  logic [WW-1:0] cyc;
  logic [WW-1:0] col [512];
  int colCnt = 0;
  int checks = 0, errors = 0;

  wave_chan_ctrl dut_i (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .threshold(threshold),
    .trigSel(trigSel), .commonTrig(commonTrig), .extTrig(extTrig),
    .roiStart(roiStart), .roiLenM1(roiLenM1), .convReq(convReq),
    .convDone(convDone), .eventPending(eventPending), .dataOut(dataOut),
    .dataValid(dataValid)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= '0;
    else       cyc <= cyc + 1'b1;
  end

  always @(negedge clk) begin
    if (dataValid && colCnt < 512) begin
      col[colCnt] = dataOut;
      colCnt = colCnt + 1;
    end
  end

  task automatic chkEq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] sval(input int n, input int t, input int sel, input int base);
    if (n == t) return SW'(2500 + base);
    if (sel != 0 && t >= 5 && n == t - 5) return SW'(2600);
    return SW'((base + n * 7) & 1023);
  endfunction

  task automatic feed(input int sel, input int base, input int t, output logic [WW-1:0] ts);
    for (int n = 0; n <= t; n++) begin
      @(negedge clk);
      sampleIn   = sval(n, t, sel, base);
      commonTrig = (sel == 1) ? (n == t) : (t >= 11 && n == t - 10);
      extTrig    = (sel == 2) ? (n == t) : (t >= 11 && n == t - 10);
      if (n == t) ts = cyc;
    end
    @(negedge clk);
    commonTrig = 0;
    extTrig = 0;
  endtask

  task automatic runEvent(input int sel, input int st, input int lm1, input int base, input int lat);
    logic [WW-1:0] ts;
    int b0;
    trigSel = 2'(sel); roiStart = 6'(st); roiLenM1 = 6'(lm1);
    b0 = colCnt;
    feed(sel, base, 70, ts);
    chkEq("R3 pending after trigger", eventPending, 1);
    chkEq("R6 no request while frozen", convReq, 0);
    @(negedge clk);
    chkEq("R6 request raised", convReq, 1);
    repeat (lat) @(negedge clk);
    chkEq("R6 request held", convReq, 1);
    convDone = 1;
    @(negedge clk);
    convDone = 0;
    chkEq("R9 rearm at conversion end", eventPending, 0);
    repeat (lm1 + 6) @(negedge clk);
    chkEq("R8 word count", colCnt - b0, lm1 + 2);
    chkEq("R7 timestamp first", col[b0], ts);
    for (int i = 0; i <= lm1; i++)
      chkEq("R2 window sample", col[b0 + 1 + i], sval(7 + ((st + i) & 63), 70, sel, base));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [WW-1:0] tsA, tsB, tsD;
    int b0;
    repeat (3) @(negedge clk);
    chkEq("R1 reset pending", eventPending, 0);
    chkEq("R1 reset request", convReq, 0);
    chkEq("R1 reset valid", dataValid, 0);
    rstN = 1;

    for (int v = 0; v < 6; v++)
      runEvent(VEC[v][31:30], VEC[v][29:24], VEC[v][23:18], VEC[v][17:8], VEC[v][7:0]);

    // R4: select 3 ignores pulses and crossings
    trigSel = 2'd3;
    feed(3, 5, 20, tsD);
    repeat (3) @(negedge clk);
    chkEq("R4 disabled select", eventPending, 0);

    // R5: strict crossing, no retrigger on held level
    trigSel = 2'd0;
    @(negedge clk) sampleIn = 12'd100;
    @(negedge clk) sampleIn = 12'd2000;
    @(negedge clk);
    @(negedge clk);
    chkEq("R5 equal is not a crossing", eventPending, 0);
    sampleIn = 12'd2001;
    @(negedge clk);
    chkEq("R5 crossing fires", eventPending, 1);
    @(negedge clk);
    convDone = 1;
    @(negedge clk);
    convDone = 0;
    repeat (5) @(negedge clk);
    chkEq("R5 held level no retrigger", eventPending, 0);
    repeat (70) @(negedge clk);

    // R10 / R11: conversion ends during a stream
    trigSel = 2'd2; roiStart = 6'd0; roiLenM1 = 6'd63;
    b0 = colCnt;
    feed(2, 50, 70, tsA);
    @(negedge clk);
    extTrig = 1;
    @(negedge clk);
    extTrig = 0;
    convDone = 1;
    @(negedge clk);
    convDone = 0;
    chkEq("R11 trigger while pending ignored", eventPending, 0);
    roiStart = 6'd60; roiLenM1 = 6'd3;
    feed(2, 90, 3, tsB);
    chkEq("R9 trigger accepted during stream", eventPending, 1);
    @(negedge clk);
    convDone = 1;
    @(negedge clk);
    convDone = 0;
    @(negedge clk);
    chkEq("R10 held frozen while streaming", eventPending, 1);
    chkEq("R10 request dropped", convReq, 0);
    repeat (80) @(negedge clk);
    chkEq("R10 total words", colCnt - b0, 70);
    chkEq("R7 first timestamp", col[b0], tsA);
    for (int i = 0; i < 64; i++)
      chkEq("R2 full window sample", col[b0 + 1 + i], sval(7 + i, 70, 2, 50));
    chkEq("R10 second timestamp", col[b0 + 65], tsB);
    for (int i = 0; i < 4; i++)
      chkEq("R8 wrapped window sample", col[b0 + 66 + i], sval(i, 3, 2, 90));
    chkEq("R9 idle after drain", eventPending, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule